// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external controller read and write a bank of 64 byte-wide configuration registers over a four-wire serial port. The wires are a serial clock, an active-low select, a direction signal and one shared data line. The shared data line is split at the block edge into an input, an output and an output enable. Each select-low frame has two phases. The first is an address byte, sent most significant bit first. The second is a data byte, also most significant bit first. In a write frame the controller drives both bytes. In a read frame the controller raises the direction signal between the 7th and 8th serial clock rises, and the slave then drives the data byte back on the shared line.

The serial inputs are oversampled by the chip clock. Each input passes through a resynchronising chain, and a rising serial clock is detected from the synchronised copy. Only address bits 6 down to 1 pick a register, so bits 7 and 0 are don't-care. All 64 registers are also exposed in parallel as a flat read-only vector for the surrounding logic.

Top module: `scp_slave`

## Requirements
- R1: Synchronous active-low reset sets every register to 0x00, holds `sd_oe` low and clears the frame position.
- R2: A write frame shifts 8 address bits then 8 data bits, each most significant bit first, one bit per serial clock rise. After the 16th rise the selected register holds the whole data byte.
- R3: The register index is address bits [6:1]. Address bits 7 and 0 have no effect, so address bytes 0x04, 0x05 and 0x85 all select register 2.
- R4: In a read frame (`rw` high before the 8th rise), the slave loads the selected register after the 8th rise and presents bit 7 on `sd_out`. It then moves to the next lower bit after each of rises 9 to 15, so the controller samples bits 7..0 on rises 9..16.
- R5: `sd_oe` is high only while select is low, `rw` is high and the frame is in its data phase (after the 8th rise and up to the 16th). It stays low throughout write frames.
- R6: Raising `cs_n` before the 16th rise abandons the frame. No register changes, `sd_oe` drops, and the next frame starts from the first address bit.
- R7: Serial clock rises past the 16th within one select-low period are ignored. They cause no further write, and `sd_oe` stays low.
- R8: `regs_flat[8*i +: 8]` always shows the current content of register i.
- R9: Read frames and idle time leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock used to oversample the serial port |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller |
| cs_n | input | 1 | Active-low frame select |
| rw | input | 1 | Data phase direction, high for read |
| sd_in | input | 1 | Serial data from the shared line |
| sd_out | output | 1 | Serial data toward the shared line |
| sd_oe | output | 1 | Drive enable for the shared line |
| regs_flat | output | 512 | Parallel view of all 64 registers, register i at bits 8*i+7..8*i |

## Verification
Writes are tried with distinct byte patterns at the lowest, an interior and the highest index. Read-back then checks that bit order and index decode are correct at both ends of the bank. Address bytes that differ only in bits 7 and 0 are used for both writing and reading, which shows whether those bits leak into the decode. Frames cut short in the address or data phase, and frames with extra clock rises, show apart a design that commits only on the exact 16th rise from one that writes early, late or more than once. The parallel view is compared after every frame to catch any stray write, including writes during reads.

// File: rtl/scp_pkg.sv
// Shared sizes and typed constants for the serial configuration port.
// Assumes one address byte and one data byte per frame.
package scp_pkg;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int SEL_W       = 6;
    localparam int NUM_REGS    = 1 << SEL_W;
    localparam int FRAME_EDGES = ADDR_W + DATA_W;
    localparam int CNT_W       = $clog2(FRAME_EDGES + 1);
    localparam int FLAT_W      = NUM_REGS * DATA_W;

    localparam logic [CNT_W-1:0] CNT_ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] CNT_DATA_FIRST = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] CNT_LAST      = CNT_W'(FRAME_EDGES - 1);
    localparam logic [CNT_W-1:0] CNT_DONE      = CNT_W'(FRAME_EDGES);

    typedef logic [DATA_W-1:0] reg_t;
    typedef logic [SEL_W-1:0]  sel_t;
endpackage

// File: rtl/scp_sync.sv
// Multi-stage resynchroniser for asynchronous port inputs.
// Assumes STAGES >= 2; each bit resets to its RST_VAL bit.
module scp_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Later stages settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scp_frame.sv
// Frame engine: counts serial clock rises, assembles the address and
// write data, loads and shifts the read byte, and controls the drive
// enable. Assumes all inputs are already synchronous to clk.
module scp_frame
    import scp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic             rw_s,
    input  logic             sd_s,
    input  reg_t             rd_data,
    output sel_t             rd_sel,
    output sel_t             wr_sel,
    output logic             wr_en,
    output reg_t             wr_data,
    output logic             sd_out,
    output logic             sd_oe,
    output logic [CNT_W-1:0] bit_cnt
);
    logic              sclk_d;
    logic              rise;
    logic [DATA_W-2:0] in_sr;
    reg_t              tx_sr;
    sel_t              sel_q;
    logic              is_rd;
    logic              oe_q;

    // Delayed serial clock for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_d;

    // Frame position, shifters and direction; select high discards the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) begin
            bit_cnt <= '0;
            in_sr   <= '0;
            tx_sr   <= '0;
            sel_q   <= '0;
            is_rd   <= 1'b0;
            oe_q    <= 1'b0;
        end else if (rise && bit_cnt < CNT_DONE) begin
            bit_cnt <= bit_cnt + 1'b1;
            in_sr   <= {in_sr[DATA_W-3:0], sd_s};
            if (bit_cnt == CNT_ADDR_LAST) begin
                sel_q <= in_sr[SEL_W-1:0];
                is_rd <= rw_s;
                oe_q  <= rw_s;
                tx_sr <= rd_data;
            end else if (bit_cnt == CNT_LAST) begin
                oe_q  <= 1'b0;
            end else if (bit_cnt >= CNT_DATA_FIRST) begin
                tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
            end
        end
    end

    // Address bits 6..1 sit in the low shifter bits after seven rises.
    assign rd_sel  = in_sr[SEL_W-1:0];
    assign wr_sel  = sel_q;
    assign wr_data = {in_sr, sd_s};
    // Commit a write exactly on the final rise of a write frame.
    assign wr_en   = rise & ~cs_n_s & ~is_rd & (bit_cnt == CNT_LAST);
    assign sd_out  = tx_sr[DATA_W-1];
    assign sd_oe   = oe_q & rw_s & ~cs_n_s;
endmodule

// File: rtl/scp_regbank.sv
// Bank of byte registers with one write port, one indexed read port
// and a flat parallel view. Assumes a single-cycle write strobe.
module scp_regbank
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  sel_t              wr_sel,
    input  reg_t              wr_data,
    input  sel_t              rd_sel,
    output reg_t              rd_data,
    output logic [FLAT_W-1:0] regs_flat
);
    reg_t regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Each register loads when the strobe addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs[g] <= '0;
            else if (wr_en && wr_sel == SEL_W'(g))       regs[g] <= wr_data;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rd_data = regs[rd_sel];
endmodule

// File: rtl/scp_slave.sv
// Top of the serial configuration slave: resynchronises the port,
// runs the frame engine and holds the register bank.
// Assumes sclk half periods span several clk cycles.
module scp_slave
    import scp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              rw,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic [FLAT_W-1:0] regs_flat
);
    logic [3:0]       raw_in;
    logic [3:0]       syn_in;
    logic             sclk_s, cs_n_s, rw_s, sd_s;
    logic             wr_en;
    sel_t             wr_sel, rd_sel;
    reg_t             wr_data, rd_data;
    logic [CNT_W-1:0] bit_cnt;

    assign raw_in = {sclk, cs_n, rw, sd_in};

    scp_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b0100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    assign {sclk_s, cs_n_s, rw_s, sd_s} = syn_in;

    scp_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .cs_n_s  (cs_n_s),
        .rw_s    (rw_s),
        .sd_s    (sd_s),
        .rd_data (rd_data),
        .rd_sel  (rd_sel),
        .wr_sel  (wr_sel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sd_out  (sd_out),
        .sd_oe   (sd_oe),
        .bit_cnt (bit_cnt)
    );

    scp_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .regs_flat (regs_flat)
    );
endmodule

// File: rtl/scp_slave_chk.sv
// Property checker for scp_slave, attached by bind. Observes the
// synchronised select, frame position, write strobe and outputs.
module scp_slave_chk
    import scp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_s,
    input logic              sd_oe,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              wr_en,
    input logic [FLAT_W-1:0] regs_flat
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0 && !sd_oe));

    p_oe_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (!cs_n_s && bit_cnt >= CNT_DATA_FIRST && bit_cnt <= CNT_LAST));

    p_idle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (bit_cnt == '0 && !sd_oe));

    p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_DONE);

    p_hold_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
endmodule

bind scp_slave scp_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_s    (cs_n_s),
    .sd_oe     (sd_oe),
    .bit_cnt   (bit_cnt),
    .wr_en     (wr_en),
    .regs_flat (regs_flat)
);

// File: tb/scp_slave_bench.sv
// Scoreboard bench: frame tasks push expected read bytes, a monitor
// collects bits on the serial clock and compares them.
module scp_slave_bench;
    localparam int HALF = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         rw = 1'b0;
    logic         sd_in = 1'b0;
    logic         sd_out;
    logic         sd_oe;
    logic [511:0] regs_flat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [64];
    logic [7:0] exp_q [$];

    always #4 clk = ~clk;

    scp_slave u_scp_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .rw        (rw),
        .sd_in     (sd_in),
        .sd_out    (sd_out),
        .sd_oe     (sd_oe),
        .regs_flat (regs_flat)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of n rises; read frames raise rw before the 8th rise.
    task automatic run_frame(input logic [7:0] a, input logic [7:0] d, input bit rd, input int n);
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int k = 1; k <= n; k++) begin
            if (k <= 8)       sd_in = a[8-k];
            else if (k <= 16) sd_in = rd ? 1'b0 : d[16-k];
            else              sd_in = 1'b1;
            if (k == 8 && rd) rw = 1'b1;
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        rw = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int n);
        run_frame(a, d, 1'b0, n);
        if (n >= 16) model[a[6:1]] = d;
    endtask

    task automatic do_read(input logic [7:0] a, input int n);
        if (n >= 16) exp_q.push_back(model[a[6:1]]);
        run_frame(a, 8'h00, 1'b1, n);
    endtask

    // R8/R9: compare the parallel view with the bench model.
    task automatic check_view(input string req);
        for (int i = 0; i < 64; i++)
            chk(regs_flat[8*i +: 8] === model[i], req, 64'(regs_flat[8*i +: 8]), 64'(model[i]));
    endtask

    // Monitor: counts rises per frame and scores read data.
    initial begin
        int ecnt = 0;
        logic [7:0] got = '0;
        forever begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) begin
                ecnt = 0;
            end else begin
                ecnt++;
                if (rw && ecnt >= 9 && ecnt <= 16) begin
                    got = {got[6:0], sd_out};
                    chk(sd_oe === 1'b1, "R5 oe in read data phase", 64'(sd_oe), 64'd1);
                    if (ecnt == 16) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R4 unexpected read", 64'(got), 64'd0);
                        end else begin
                            logic [7:0] e;
                            e = exp_q.pop_front();
                            chk(got === e, "R4 read data", 64'(got), 64'(e));
                        end
                    end
                end else if (!rw && ecnt == 12) begin
                    chk(sd_oe === 1'b0, "R5 oe low in write", 64'(sd_oe), 64'd0);
                end else if (ecnt > 16) begin
                    chk(sd_oe === 1'b0, "R7 oe low past frame", 64'(sd_oe), 64'd0);
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        wait_clk(5);
        // R1: reset state
        chk(regs_flat === '0, "R1 regs after reset", 64'(regs_flat[63:0]), 64'd0);
        chk(sd_oe === 1'b0, "R1 oe after reset", 64'(sd_oe), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        wait_clk(4);

        // R2/R8: writes at low, interior and top indices
        do_write(8'h02, 8'hA5, 16);
        do_write(8'h7E, 8'h5A, 16);
        do_write(8'h00, 8'hFF, 16);
        do_write(8'h40, 8'h81, 16);
        check_view("R2 R8 write view");

        // R4: read back, R9: reads do not change registers
        do_read(8'h02, 16);
        do_read(8'h7E, 16);
        do_read(8'h00, 16);
        do_read(8'h40, 16);
        check_view("R9 after reads");

        // R3: address bits 7 and 0 ignored
        do_write(8'h85, 8'h3C, 16);
        chk(regs_flat[23:16] === 8'h3C, "R3 alias write idx2", 64'(regs_flat[23:16]), 64'h3C);
        do_read(8'h04, 16);
        do_read(8'h05, 16);
        do_write(8'h81, 8'hC3, 16);
        chk(regs_flat[7:0] === 8'hC3, "R3 alias write idx0", 64'(regs_flat[7:0]), 64'hC3);

        // R6: aborted frames leave registers untouched
        do_write(8'h02, 8'h00, 12);
        do_write(8'h02, 8'h00, 15);
        do_write(8'h7E, 8'h00, 5);
        chk(sd_oe === 1'b0, "R6 oe after abort", 64'(sd_oe), 64'd0);
        check_view("R6 abort view");
        do_read(8'h02, 10);
        do_read(8'h02, 16);

        // R7: extra rises ignored
        do_write(8'h0A, 8'h96, 24);
        chk(regs_flat[47:40] === 8'h96, "R7 extra rises write", 64'(regs_flat[47:40]), 64'h96);
        do_read(8'h0A, 20);
        check_view("R7 R9 final view");

        wait_clk(20);
        chk(exp_q.size() == 0, "R4 all reads observed", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule